// File: doc/BRIEF.md
# Wake-up power-on controller

This block drives the enable for an external system power supply. The pin is active low and open drain, so the block only asks for the pin to be pulled low. While the main supply is off, two hardware events can switch the system on. The first is a key closure on the kickstart input, which is a falling level on an asynchronous, active-low pin. The second is a one-cycle pulse from the date/time alarm comparator.

Once the main supply is valid, the hardware events no longer affect the supply enable. Software then sets or releases it through a register write, which lets a finished system power itself down. Two sticky flags record what happened: one for kickstart edges and one for alarm events. Software clears each flag by writing 1 to it. With the main supply present, the kickstart pin becomes an ordinary interrupt source that only sets its flag.

Top module: `wake_power_ctrl`

## Requirements
- R1: After a synchronous reset, `pwr_pull_low`, `kick_flag` and `wake_flag` are all 0.
- R2: With `main_ok`=0, `aux_ok`=1 and `aux_en`=1, `kick_n` goes from 1 to 0 set up before rising edge 1. `pwr_pull_low` is still 0 after edge 2 and is 1 after edge 3, and `kick_flag` becomes 1 at the same edge.
- R3: With `main_ok`=0 and either `aux_ok`=0 or `aux_en`=0, a kickstart falling edge is ignored: `pwr_pull_low` and `kick_flag` stay 0.
- R4: With `main_ok`=1, a kickstart falling edge sets `kick_flag` in the same cycle as R2 and leaves `pwr_pull_low` unchanged.
- R5: With `main_ok`=0, `alarm_hit`=1 in a cycle sets both `pwr_pull_low` and `wake_flag` at the next rising edge, whatever `aux_ok` and `aux_en` are.
- R6: With `main_ok`=1, `alarm_hit` sets `wake_flag` and leaves `pwr_pull_low` unchanged.
- R7: With `main_ok`=1, a `sw_pwr_wr` pulse loads `sw_pwr_val` into `pwr_pull_low` at the next edge, where 1 means on and 0 means released.
- R8: With `main_ok`=0, `sw_pwr_wr` has no effect on `pwr_pull_low`.
- R9: A kickstart input held low produces exactly one event. Once `kick_flag` has been cleared, it stays 0 for as long as `kick_n` stays low.
- R10: A `sw_clr_kick` or `sw_clr_wake` pulse clears its flag at the next edge. If the flag's set event arrives in the same cycle as the clear, the set wins and the flag stays 1.
- R11: A `pwr_pull_low` that hardware has set stays 1 when `main_ok` rises, until software releases it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| main_ok | input | 1 | Main supply valid |
| aux_ok | input | 1 | Auxiliary battery present |
| aux_en | input | 1 | Auxiliary battery enable bit |
| kick_n | input | 1 | Asynchronous active-low kickstart pin |
| alarm_hit | input | 1 | One-cycle date/time alarm match pulse |
| sw_pwr_wr | input | 1 | Software write strobe for the power bit |
| sw_pwr_val | input | 1 | Power bit value written by software |
| sw_clr_kick | input | 1 | Write-1 clear of the kickstart flag |
| sw_clr_wake | input | 1 | Write-1 clear of the wake-up flag |
| pwr_pull_low | output | 1 | Open-drain enable: 1 pulls the power pin low (supply on) |
| kick_flag | output | 1 | Sticky kickstart event flag |
| wake_flag | output | 1 | Sticky alarm event flag |

## Verification
The hardest situation to reach is a kickstart pin that stays low long after its single edge was taken. To show that no second event appears, the stimulus holds `kick_n` low, clears the flag while the pin is still low, and runs several more cycles. The bench also sweeps all eight combinations of main, auxiliary-present and enable for both the kickstart and the alarm source, and computes the expected power and flag values from those bits. It hands the supply to software by raising `main_ok` while the enable is held, and it drives a set and a clear of a flag into the same cycle.

// File: rtl/wpc_pkg.sv
package wpc_pkg;
  parameter int unsigned WPC_SYNC_STAGES = 2;

  // hardware wake from a kickstart edge is allowed only on battery with aux enabled
  function automatic logic kick_may_wake(input logic main_ok, input logic aux_ok,
                                         input logic aux_en);
    return (!main_ok) && aux_ok && aux_en;
  endfunction

  // kickstart edge is recorded: as interrupt on main, as wake cause on aux
  function automatic logic kick_recorded(input logic main_ok, input logic aux_ok,
                                         input logic aux_en);
    return main_ok || (aux_ok && aux_en);
  endfunction
endpackage

// File: rtl/wpc_sync_fall.sv
module wpc_sync_fall #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din_n,
  output logic fall
);
  localparam int unsigned LAST = STAGES;

  logic [LAST:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= 1'b1;
    else     chain[0] <= din_n;
  end

  genvar g;
  generate
    for (g = 1; g <= LAST; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= 1'b1;
        else     chain[g] <= chain[g-1];
      end
    end
  endgenerate

  assign fall = chain[LAST] & ~chain[LAST-1];

  assert_one_event_R9: assert property (@(posedge clk) disable iff (rst)
    fall |=> !fall);
endmodule

// File: rtl/wpc_sticky_flag.sv
module wpc_sticky_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_ev,
  input  logic clr_w1,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)         q <= 1'b0;
    else if (set_ev) q <= 1'b1;
    else if (clr_w1) q <= 1'b0;
  end

  assert_set_wins_R10: assert property (@(posedge clk) disable iff (rst)
    set_ev |=> q);
  assert_clear_R10: assert property (@(posedge clk) disable iff (rst)
    (clr_w1 && !set_ev) |=> !q);
endmodule

// File: rtl/wpc_power_latch.sv
module wpc_power_latch (
  input  logic clk,
  input  logic rst,
  input  logic main_ok,
  input  logic hw_wake,
  input  logic sw_wr,
  input  logic sw_val,
  output logic pwr_q
);
  always_ff @(posedge clk) begin
    if (rst)                   pwr_q <= 1'b0;
    else if (!main_ok) begin
      if (hw_wake)             pwr_q <= 1'b1;
    end
    else if (sw_wr)            pwr_q <= sw_val;
  end

  assert_sw_load_R7: assert property (@(posedge clk) disable iff (rst)
    (main_ok && sw_wr) |=> (pwr_q == $past(sw_val)));
  assert_sw_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    (!main_ok && !hw_wake) |=> (pwr_q == $past(pwr_q)));
  assert_hold_on_main_R11: assert property (@(posedge clk) disable iff (rst)
    (main_ok && !sw_wr) |=> $stable(pwr_q));
endmodule

// File: rtl/wake_power_ctrl.sv
module wake_power_ctrl #(
  parameter int unsigned SYNC_STAGES = wpc_pkg::WPC_SYNC_STAGES
) (
  input  logic clk,
  input  logic rst,
  input  logic main_ok,
  input  logic aux_ok,
  input  logic aux_en,
  input  logic kick_n,
  input  logic alarm_hit,
  input  logic sw_pwr_wr,
  input  logic sw_pwr_val,
  input  logic sw_clr_kick,
  input  logic sw_clr_wake,
  output logic pwr_pull_low,
  output logic kick_flag,
  output logic wake_flag
);
  import wpc_pkg::*;

  logic kick_fall;
  logic kick_wake;
  logic kick_set;
  logic hw_wake;

  wpc_sync_fall #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .din_n (kick_n),
    .fall  (kick_fall)
  );

  assign kick_wake = kick_fall && kick_may_wake(main_ok, aux_ok, aux_en);
  assign kick_set  = kick_fall && kick_recorded(main_ok, aux_ok, aux_en);
  assign hw_wake   = kick_wake || alarm_hit;

  wpc_power_latch u_pwr (
    .clk     (clk),
    .rst     (rst),
    .main_ok (main_ok),
    .hw_wake (hw_wake),
    .sw_wr   (sw_pwr_wr),
    .sw_val  (sw_pwr_val),
    .pwr_q   (pwr_pull_low)
  );

  wpc_sticky_flag u_kflag (
    .clk    (clk),
    .rst    (rst),
    .set_ev (kick_set),
    .clr_w1 (sw_clr_kick),
    .q      (kick_flag)
  );

  wpc_sticky_flag u_wflag (
    .clk    (clk),
    .rst    (rst),
    .set_ev (alarm_hit),
    .clr_w1 (sw_clr_wake),
    .q      (wake_flag)
  );

  assert_alarm_wakes_R5: assert property (@(posedge clk) disable iff (rst)
    (!main_ok && alarm_hit) |=> pwr_pull_low);
  assert_kick_gated_R3: assert property (@(posedge clk) disable iff (rst)
    (!main_ok && !(aux_ok && aux_en) && !alarm_hit && !pwr_pull_low) |=> !pwr_pull_low);
  assert_main_no_hw_R4: assert property (@(posedge clk) disable iff (rst)
    (main_ok && !sw_pwr_wr && !pwr_pull_low) |=> !pwr_pull_low);
  assert_alarm_flag_R6: assert property (@(posedge clk) disable iff (rst)
    alarm_hit |=> wake_flag);
endmodule

// File: tb/wake_power_ctrl_tb.sv
module wake_power_ctrl_tb;
  localparam time CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic main_ok = 1'b0, aux_ok = 1'b0, aux_en = 1'b0, kick_n = 1'b1, alarm_hit = 1'b0;
  logic sw_pwr_wr = 1'b0, sw_pwr_val = 1'b0, sw_clr_kick = 1'b0, sw_clr_wake = 1'b0;
  logic pwr_pull_low, kick_flag, wake_flag;
  int total = 0;
  int bad = 0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wake_power_ctrl u_dut (
    .clk(clk), .rst(rst), .main_ok(main_ok), .aux_ok(aux_ok), .aux_en(aux_en),
    .kick_n(kick_n), .alarm_hit(alarm_hit), .sw_pwr_wr(sw_pwr_wr),
    .sw_pwr_val(sw_pwr_val), .sw_clr_kick(sw_clr_kick), .sw_clr_wake(sw_clr_wake),
    .pwr_pull_low(pwr_pull_low), .kick_flag(kick_flag), .wake_flag(wake_flag)
  );

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic check(input logic act, input logic exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; main_ok = 0; aux_ok = 0; aux_en = 0; kick_n = 1; alarm_hit = 0;
    sw_pwr_wr = 0; sw_pwr_val = 0; sw_clr_kick = 0; sw_clr_wake = 0;
    step(2);
    rst = 1'b0;
  endtask

  initial begin
    do_reset();
    check(pwr_pull_low, 1'b0, "R1 pwr");
    check(kick_flag, 1'b0, "R1 kick_flag");
    check(wake_flag, 1'b0, "R1 wake_flag");

    // kickstart sweep over main/aux/enable
    for (int c = 0; c < 8; c++) begin
      logic m, a, e, ep, ek;
      m = c[2]; a = c[1]; e = c[0];
      ep = !m && a && e;
      ek = m || (a && e);
      do_reset();
      main_ok = m; aux_ok = a; aux_en = e;
      kick_n = 1'b0;
      step(2);
      check(pwr_pull_low, 1'b0, "R2 latency edge2");
      step(1);
      check(pwr_pull_low, ep, ep ? "R2 pwr" : (m ? "R4 pwr" : "R3 pwr"));
      check(kick_flag, ek, ek ? (m ? "R4 flag" : "R2 flag") : "R3 flag");
      kick_n = 1'b1;
      step(3);
    end

    // alarm sweep over main/aux/enable
    for (int c = 0; c < 8; c++) begin
      logic m;
      m = c[2];
      do_reset();
      main_ok = m; aux_ok = c[1]; aux_en = c[0];
      alarm_hit = 1'b1;
      step(1);
      alarm_hit = 1'b0;
      check(pwr_pull_low, !m, m ? "R6 pwr" : "R5 pwr");
      check(wake_flag, 1'b1, m ? "R6 flag" : "R5 flag");
    end

    // single event for a held key, then handover to software
    do_reset();
    aux_ok = 1; aux_en = 1;
    kick_n = 1'b0;
    step(3);
    check(pwr_pull_low, 1'b1, "R9 first event");
    sw_clr_kick = 1'b1; step(1); sw_clr_kick = 1'b0;
    check(kick_flag, 1'b0, "R10 clear kick");
    step(10);
    check(kick_flag, 1'b0, "R9 held low no second event");
    main_ok = 1'b1;
    step(3);
    check(pwr_pull_low, 1'b1, "R11 held after main returns");
    sw_pwr_wr = 1; sw_pwr_val = 0; step(1); sw_pwr_wr = 0;
    check(pwr_pull_low, 1'b0, "R7 release");
    sw_pwr_wr = 1; sw_pwr_val = 1; step(1); sw_pwr_wr = 0;
    check(pwr_pull_low, 1'b1, "R7 set");
    sw_pwr_wr = 1; sw_pwr_val = 0; step(1); sw_pwr_wr = 0;
    check(pwr_pull_low, 1'b0, "R7 release again");
    kick_n = 1'b1;
    step(3);

    // software write ignored on battery
    main_ok = 1'b0;
    sw_pwr_wr = 1; sw_pwr_val = 1; step(1); sw_pwr_wr = 0;
    step(1);
    check(pwr_pull_low, 1'b0, "R8 write ignored");

    // flag clear and set/clear collision
    main_ok = 1'b1;
    alarm_hit = 1; step(1); alarm_hit = 0;
    check(wake_flag, 1'b1, "R6 set");
    sw_clr_wake = 1; step(1); sw_clr_wake = 0;
    check(wake_flag, 1'b0, "R10 clear wake");
    alarm_hit = 1; sw_clr_wake = 1; step(1); alarm_hit = 0; sw_clr_wake = 0;
    check(wake_flag, 1'b1, "R10 set wins");
    check(pwr_pull_low, 1'b0, "R6 no power on main");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule